// File: doc/BRIEF.md
# Sleep Entry and Wake Sequencer

This block controls the low-power sleep state of a synchronous memory macro. The sleep request arrives asynchronously and is active high. The block passes it through a flop synchronizer and then counts a fixed number of clocks before it enters sleep. It also counts a fixed number of clocks when it wakes. While asleep, the block raises an input gate and a force-high-impedance signal for the data drivers, and it drops every incoming command. Storage and register contents are left untouched during sleep.

After the request is released, the block opens a recovery window. During this window only deselect and read commands are allowed through. A write or a burst-continue issued in the window is dropped and flagged as an error for that cycle.

If the request falls again before the entry count finishes, the sequencer returns straight to the awake state and never asserts sleep.

Top module: `lp_sleep_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `in_gate_o`, `hiz_o` and `recov_o` are low.
- R2: The request passes through SYNC_STAGES flops. If `slp_req_i` is held high, `in_gate_o` and `hiz_o` rise after the (SYNC_STAGES+ENTRY_CYCLES+1)th rising edge at which the request is sampled high. With the defaults this is the 5th edge.
- R3: A request sampled high on ENTRY_CYCLES or fewer consecutive edges never raises `in_gate_o`, and the block stays awake.
- R4: While `in_gate_o` is high, `hiz_o` is high, `cmd_fwd_o` and `cmd_err_o` are low, and `cmd_op_o` is 0, whatever command is presented.
- R5: Once the request is sampled low, `in_gate_o` falls after the (SYNC_STAGES+1)th edge. `recov_o` is then high for exactly WAKE_CYCLES cycles, and normal operation follows.
- R6: The op codes are 0 = deselect, 1 = read, 2 = write and 3 = burst continue. While `recov_o` is high, codes 0 and 1 are forwarded. Codes 2 and 3 are dropped (`cmd_fwd_o` low) with `cmd_err_o` high.
- R7: `cmd_err_o` is high only when `cmd_valid_i` is high and `recov_o` is high.
- R8: In normal operation every valid op is forwarded, with `cmd_op_o` equal to `cmd_op_i`. Whenever `cmd_fwd_o` is low, `cmd_op_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slp_req_i | input | 1 | Asynchronous sleep request, active high |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | Command op code (see R6) |
| in_gate_o | output | 1 | Command inputs disabled (asleep) |
| hiz_o | output | 1 | Force data drivers to high impedance |
| recov_o | output | 1 | Wake recovery window active |
| cmd_fwd_o | output | 1 | Command forwarded to the core |
| cmd_op_o | output | 2 | Forwarded op code, 0 when none |
| cmd_err_o | output | 1 | Illegal command during recovery |

## Verification
The bench builds the block with its defaults: two synchronizer stages, two entry clocks and two wake clocks. This makes the entry latency exactly five edges and the recovery window exactly two cycles, so every op code can be shown in both recovery slots over a few sleep cycles. Short request pulses of one and two sampled edges bracket the abort boundary against the entry count. A reset applied mid-sleep checks that the block returns to the awake state with no recovery window.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef enum logic [1:0] {
        OP_DESEL = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_CONT  = 2'd3
    } lp_op_e;

    typedef enum logic [1:0] {
        ST_AWAKE,
        ST_ENTER,
        ST_SLEEP,
        ST_WAKE
    } lp_state_e;

    typedef struct packed {
        logic gate;
        logic hiz;
        logic recov;
    } lp_status_t;

    function automatic logic op_ok_in_recovery(lp_op_e op);
        return (op == OP_DESEL) || (op == OP_READ);
    endfunction

    function automatic int cnt_bits(int a, int b);
        int m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES <= 1) begin : g_single
            logic s;
            always_ff @(posedge clk) begin
                if (rst) s <= 1'b0;
                else     s <= d_i;
            end
            assign q_o = s;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], d_i};
            end
            assign q_o = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
    import lp_pkg::*;
#(
    parameter int ENTRY_CYCLES = 2,
    parameter int WAKE_CYCLES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_s_i,
    output lp_status_t status_o
);
    localparam int CW = cnt_bits(ENTRY_CYCLES, WAKE_CYCLES);
    localparam logic [CW-1:0] ENTRY_LOAD = CW'(ENTRY_CYCLES - 1);
    localparam logic [CW-1:0] WAKE_LOAD  = CW'(WAKE_CYCLES - 1);

    lp_state_e      state;
    logic [CW-1:0]  cnt;
    logic           cnt_done;

    assign cnt_done = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_AWAKE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_AWAKE: begin
                    if (req_s_i) begin
                        state <= ST_ENTER;
                        cnt   <= ENTRY_LOAD;
                    end
                end
                ST_ENTER: begin
                    if (!req_s_i)     state <= ST_AWAKE;
                    else if (cnt_done) state <= ST_SLEEP;
                    else               cnt   <= cnt - 1'b1;
                end
                ST_SLEEP: begin
                    if (!req_s_i) begin
                        state <= ST_WAKE;
                        cnt   <= WAKE_LOAD;
                    end
                end
                default: begin
                    if (cnt_done) state <= ST_AWAKE;
                    else          cnt   <= cnt - 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        status_o.gate  = (state == ST_SLEEP);
        status_o.hiz   = (state == ST_SLEEP);
        status_o.recov = (state == ST_WAKE);
    end
endmodule

// File: rtl/lp_filter.sv
module lp_filter
    import lp_pkg::*;
(
    input  lp_status_t status_i,
    input  logic       valid_i,
    input  lp_op_e     op_i,
    output logic       fwd_o,
    output lp_op_e     op_o,
    output logic       err_o
);
    logic legal;

    always_comb begin
        legal = !status_i.recov || op_ok_in_recovery(op_i);
        fwd_o = valid_i && !status_i.gate && legal;
        err_o = valid_i && status_i.recov && !op_ok_in_recovery(op_i);
        op_o  = fwd_o ? op_i : OP_DESEL;
    end
endmodule

// File: rtl/lp_sleep_ctrl.sv
module lp_sleep_ctrl
    import lp_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int ENTRY_CYCLES = 2,
    parameter int WAKE_CYCLES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slp_req_i,
    input  logic       cmd_valid_i,
    input  logic [1:0] cmd_op_i,
    output logic       in_gate_o,
    output logic       hiz_o,
    output logic       recov_o,
    output logic       cmd_fwd_o,
    output logic [1:0] cmd_op_o,
    output logic       cmd_err_o
);
    logic       req_s;
    lp_status_t status;
    lp_op_e     op_fwd;

    lp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (slp_req_i),
        .q_o (req_s)
    );

    lp_fsm #(
        .ENTRY_CYCLES (ENTRY_CYCLES),
        .WAKE_CYCLES  (WAKE_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_s_i  (req_s),
        .status_o (status)
    );

    lp_filter u_filter (
        .status_i (status),
        .valid_i  (cmd_valid_i),
        .op_i     (lp_op_e'(cmd_op_i)),
        .fwd_o    (cmd_fwd_o),
        .op_o     (op_fwd),
        .err_o    (cmd_err_o)
    );

    assign cmd_op_o  = op_fwd;
    assign in_gate_o = status.gate;
    assign hiz_o     = status.hiz;
    assign recov_o   = status.recov;
endmodule

// File: rtl/lp_sleep_chk.sv
module lp_sleep_chk #(
    parameter int WAKE_CYCLES = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       slp_req_i,
    input logic       cmd_valid_i,
    input logic [1:0] cmd_op_i,
    input logic       in_gate_o,
    input logic       hiz_o,
    input logic       recov_o,
    input logic       cmd_fwd_o,
    input logic [1:0] cmd_op_o,
    input logic       cmd_err_o
);
    int cyc;
    int rcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc  <= 0;
            rcnt <= 0;
        end else begin
            if (cyc < 3) cyc <= cyc + 1;
            rcnt <= recov_o ? rcnt + 1 : 0;
        end
    end

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        rst |=> (!in_gate_o && !recov_o));

    // R2
    entry_req_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3 && $rose(in_gate_o)) |-> $past(slp_req_i, 2));

    // R4
    sleep_drop_chk: assert property (@(posedge clk) disable iff (rst)
        in_gate_o |-> (hiz_o && !cmd_fwd_o && !cmd_err_o && !recov_o));

    // R5
    wake_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(in_gate_o) |-> recov_o);

    // R5
    wake_len_chk: assert property (@(posedge clk) disable iff (rst)
        recov_o |-> (rcnt < WAKE_CYCLES));

    // R6
    recov_block_chk: assert property (@(posedge clk) disable iff (rst)
        (recov_o && cmd_valid_i && cmd_op_i[1]) |-> (cmd_err_o && !cmd_fwd_o));

    // R7
    err_scope_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err_o |-> (recov_o && cmd_valid_i));

    // R8
    idle_op_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_fwd_o |-> (cmd_op_o == 2'd0));
endmodule

bind lp_sleep_ctrl lp_sleep_chk #(.WAKE_CYCLES(WAKE_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .slp_req_i   (slp_req_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .in_gate_o   (in_gate_o),
    .hiz_o       (hiz_o),
    .recov_o     (recov_o),
    .cmd_fwd_o   (cmd_fwd_o),
    .cmd_op_o    (cmd_op_o),
    .cmd_err_o   (cmd_err_o)
);

// File: tb/lp_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module lp_sleep_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       cv  = 1'b0;
    logic [1:0] op  = 2'd0;
    logic       gate, hiz, recov, fwd, err;
    logic [1:0] op_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic       gate;
        logic       recov;
        logic       fwd;
        logic       err;
        logic [1:0] op;
        int         rid;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    lp_sleep_ctrl u_dut (
        .clk (clk), .rst (rst), .slp_req_i (req),
        .cmd_valid_i (cv), .cmd_op_i (op),
        .in_gate_o (gate), .hiz_o (hiz), .recov_o (recov),
        .cmd_fwd_o (fwd), .cmd_op_o (op_o), .cmd_err_o (err)
    );

    function automatic logic ok_rec(logic [1:0] o);
        return o < 2'd2;
    endfunction

    // Driver: one call = one cycle; expected outputs before the next edge.
    task automatic step(input logic rq, input logic v, input logic [1:0] o,
                        input logic eg, input logic er, input logic ef,
                        input logic ee, input int rid);
        exp_t e;
        @(negedge clk);
        req = rq; cv = v; op = o;
        e.gate = eg; e.recov = er; e.fwd = ef; e.err = ee;
        e.op = ef ? o : 2'd0; e.rid = rid;
        q.push_back(e);
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if ({gate, hiz, recov, fwd, err, op_o} !==
                    {e.gate, e.gate, e.recov, e.fwd, e.err, e.op}) begin
                    bad++;
                    $display("FAIL R%0d: got gate/hiz/rec/fwd/err/op=%b%b%b%b%b%0d exp=%b%b%b%b%b%0d",
                             e.rid, gate, hiz, recov, fwd, err, op_o,
                             e.gate, e.gate, e.recov, e.fwd, e.err, e.op);
                end
            end
        end
    end

    // R2 R4: request from awake to asleep, commands dropped once asleep
    task automatic enter_sleep();
        step(1, 1, 2'd1, 0, 0, 1, 0, 2);
        repeat (4) step(1, 1, 2'd1, 0, 0, 1, 0, 2);
        step(1, 1, 2'd2, 1, 0, 0, 0, 4);
        step(1, 1, 2'd0, 1, 0, 0, 0, 4);
        step(1, 1, 2'd3, 1, 0, 0, 0, 4);
    endtask

    // R5 R6 R7: release, then two recovery cycles with chosen commands
    task automatic exit_sleep(input logic va, input logic [1:0] oa,
                              input logic vb, input logic [1:0] ob);
        repeat (3) step(0, 1, 2'd2, 1, 0, 0, 0, 5);
        step(0, va, oa, 0, 1, va && ok_rec(oa), va && !ok_rec(oa), 6);
        step(0, vb, ob, 0, 1, vb && ok_rec(ob), vb && !ok_rec(ob), 7);
        step(0, 1, 2'd2, 0, 0, 1, 0, 5);
        step(0, 1, 2'd3, 0, 0, 1, 0, 8);
    endtask

    initial begin
        // R1: reset state
        step(0, 1, 2'd2, 0, 0, 1, 0, 1);
        step(1, 0, 2'd0, 0, 0, 0, 0, 1);
        step(1, 0, 2'd0, 0, 0, 0, 0, 1);
        @(negedge clk); rst = 1'b0; req = 1'b0;
        step(0, 0, 2'd0, 0, 0, 0, 0, 1);
        repeat (3) step(0, 0, 2'd0, 0, 0, 0, 0, 1);

        // R8: normal operation forwards all ops; invalid gives op 0
        for (int k = 0; k < 4; k++) step(0, 1, 2'(k), 0, 0, 1, 0, 8);
        step(0, 0, 2'd2, 0, 0, 0, 0, 8);

        // R6: write in first recovery slot, read in second
        enter_sleep();
        exit_sleep(1, 2'd2, 1, 2'd1);
        // R6: deselect, then burst continue
        enter_sleep();
        exit_sleep(1, 2'd0, 1, 2'd3);
        // R7: invalid write during recovery raises no error
        enter_sleep();
        exit_sleep(0, 2'd2, 0, 2'd3);

        // R3: one-edge pulse
        step(1, 0, 2'd0, 0, 0, 0, 0, 3);
        repeat (7) step(0, 0, 2'd0, 0, 0, 0, 0, 3);
        step(0, 1, 2'd2, 0, 0, 1, 0, 3);
        // R3: pulse of exactly ENTRY_CYCLES sampled edges
        step(1, 0, 2'd0, 0, 0, 0, 0, 3);
        step(1, 0, 2'd0, 0, 0, 0, 0, 3);
        repeat (7) step(0, 0, 2'd0, 0, 0, 0, 0, 3);
        step(0, 1, 2'd3, 0, 0, 1, 0, 3);

        // R1: reset while asleep returns awake with no recovery window
        enter_sleep();
        @(negedge clk); rst = 1'b1; req = 1'b0; cv = 1'b0;
        step(0, 0, 2'd0, 0, 0, 0, 0, 1);
        @(negedge clk); rst = 1'b0;
        repeat (4) step(0, 1, 2'd2, 0, 0, 1, 0, 1);

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule